// File: doc/BRIEF.md
# Shared-Memory Mailbox Interrupt Controller

This block links two bus masters that share one dual-port word store. The left master is a host bridge with an 8-bit-derived 16-bit access path and no ready input; the right master is a signal processor. Neither side can be held off by a busy or wait-state signal, so the two use the store cooperatively. Each side owns a one-byte mailbox. Writing a mailbox raises an active-low interrupt at the other side, and the other side reading that mailbox clears it. By convention a mailbox value of 0x00 means its owner is using the shared buffer, and 0xFF means the owner has let it go. A master that sees the other mailbox at any value other than 0xFF waits for the next interrupt and checks again before it touches the shared area.

Both ports see the same decoded map. Address 0x0000 selects the left-owned mailbox and address 0x8000 selects the right-owned mailbox. Any other address selects a word of the shared store, indexed by its low 11 bits. All strobes are sampled on one system clock. An access happens once, on the clock where the strobe is first seen low. A read result appears on the cycle after that and stays until the next read on the same port.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high, both read-data outputs are 0x0000, and a read of either mailbox address returns 0x00FF.
- R2: A strobe that stays low for several clocks counts as one access. Only the data present on the first low clock is written.
- R3: A left-port write to address 0x0000 drives `irq_to_right_n` low on the clock after the write.
- R4: A right-port read of address 0x0000 returns `irq_to_right_n` high on the clock after the read.
- R5: A right-port write to address 0x8000 drives `irq_to_left_n` low on the clock after the write.
- R6: A left-port read of address 0x8000 returns `irq_to_left_n` high on the clock after the read.
- R7: A mailbox write stores the low 8 bits of the write data. A mailbox read from either port returns that byte zero-extended to 16 bits.
- R8: When an interrupt is set and cleared on the same clock, the set wins and the output is low. The read in that clock returns the mailbox value from before the write.
- R9: The shared store holds 2048 words of 16 bits. A word written from one port reads back from the other port. Both ports may read the same word on the same clock and both get it.
- R10: Read data is presented on the clock after the read strobe is first seen low. It holds unchanged until that port's next read.
- R11: If both ports write the same store word on one clock, the left port's data is kept. A read of a word on the same clock as a write to it returns the old contents.
- R12: Any other access has no effect on the interrupts. This covers a left write to 0x8000, a right write to 0x0000, left reads of 0x0000 and right reads of 0x8000, and store accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | 16 | Left port address |
| l_wdata | input | 16 | Left port write data |
| l_rd_n | input | 1 | Left port read strobe, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_rdata | output | 16 | Left port read data |
| r_addr | input | 16 | Right port address |
| r_wdata | input | 16 | Right port write data |
| r_rd_n | input | 1 | Right port read strobe, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_rdata | output | 16 | Right port read data |
| irq_to_right_n | output | 1 | Interrupt to the right master, active low |
| irq_to_left_n | output | 1 | Interrupt to the left master, active low |

## Verification
Two functions can land on the same clock: raising an interrupt, through a mailbox write on one port, and clearing it, through a mailbox read on the other port. The bench provokes this by striking both strobes in one clock, once for each direction. It then judges that the interrupt ends low and that the read returned the mailbox byte from before the write. A second collision is two writes to the same store word on one clock. It is judged by reading the word back and expecting the left data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    RGN_STORE = 2'd0,
    RGN_LBOX  = 2'd1,
    RGN_RBOX  = 2'd2
  } region_e;

  // Map a bus address onto one of the three targets.
  function automatic region_e decode_region(input logic [15:0] addr,
                                            input logic [15:0] lbox_addr,
                                            input logic [15:0] rbox_addr);
    if (addr == lbox_addr)      return RGN_LBOX;
    else if (addr == rbox_addr) return RGN_RBOX;
    else                        return RGN_STORE;
  endfunction

  // A mailbox byte seen on the 16-bit read bus.
  function automatic logic [15:0] widen_box(input logic [7:0] box);
    return {8'h00, box};
  endfunction

  // Next state of an interrupt request flag: raising beats clearing.
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/mbx_strobe_edge.sv
module mbx_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fire
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  assign fire = ~strobe_n & strobe_q;

  // R2: a held strobe produces a single access
  a_r2_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_n
);
  import mbx_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, set_ev, clr_ev);
  end

  assign irq_n = ~flag_q;

  // R8: a set in the same clock as a clear leaves the request pending
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> !irq_n);

  // R4 / R6: a lone clear releases the line
  a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> irq_n);

  // R12: no event, no change
  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 16,
  parameter int          BOX_W     = 8,
  parameter logic [15:0] LBOX_ADDR = 16'h0000,
  parameter logic [15:0] RBOX_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_rd_fire,
  input  logic              l_wr_fire,
  input  logic [15:0]       l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_rd_fire,
  input  logic              r_wr_fire,
  input  logic [15:0]       r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [BOX_W-1:0]  lbox,
  output logic [BOX_W-1:0]  rbox
);
  import mbx_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [BOX_W-1:0] BOX_FREE = {BOX_W{1'b1}};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BOX_W-1:0]  lbox_q, rbox_q;
  region_e           l_rgn, r_rgn;
  logic [ADDR_W-1:0] l_idx, r_idx;
  logic [DATA_W-1:0] l_rd_val, r_rd_val;

  assign l_rgn = decode_region(l_addr, LBOX_ADDR, RBOX_ADDR);
  assign r_rgn = decode_region(r_addr, LBOX_ADDR, RBOX_ADDR);
  assign l_idx = l_addr[ADDR_W-1:0];
  assign r_idx = r_addr[ADDR_W-1:0];

  // Store array: the left port is applied last, so it wins a tie.
  always_ff @(posedge clk) begin
    if (r_wr_fire && r_rgn == RGN_STORE) mem[r_idx] <= r_wdata;
    if (l_wr_fire && l_rgn == RGN_STORE) mem[l_idx] <= l_wdata;
  end

  // Mailbox bytes, left port again wins a tie.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbox_q <= BOX_FREE;
      rbox_q <= BOX_FREE;
    end else begin
      if (r_wr_fire && r_rgn == RGN_LBOX) lbox_q <= r_wdata[BOX_W-1:0];
      if (r_wr_fire && r_rgn == RGN_RBOX) rbox_q <= r_wdata[BOX_W-1:0];
      if (l_wr_fire && l_rgn == RGN_LBOX) lbox_q <= l_wdata[BOX_W-1:0];
      if (l_wr_fire && l_rgn == RGN_RBOX) rbox_q <= l_wdata[BOX_W-1:0];
    end
  end

  always_comb begin
    unique case (l_rgn)
      RGN_LBOX: l_rd_val = DATA_W'(widen_box(lbox_q));
      RGN_RBOX: l_rd_val = DATA_W'(widen_box(rbox_q));
      default:  l_rd_val = mem[l_idx];
    endcase
    unique case (r_rgn)
      RGN_LBOX: r_rd_val = DATA_W'(widen_box(lbox_q));
      RGN_RBOX: r_rd_val = DATA_W'(widen_box(rbox_q));
      default:  r_rd_val = mem[r_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd_fire) l_rdata <= l_rd_val;
      if (r_rd_fire) r_rdata <= r_rd_val;
    end
  end

  assign lbox = lbox_q;
  assign rbox = rbox_q;

  // R10: read data only moves on a read
  a_r10_l_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd_fire |=> $stable(l_rdata));
  a_r10_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd_fire |=> $stable(r_rdata));

  // R7: mailbox bytes only move on a write to them
  a_r7_lbox_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !((l_wr_fire && l_rgn == RGN_LBOX) || (r_wr_fire && r_rgn == RGN_LBOX))
      |=> $stable(lbox));
  a_r7_rbox_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !((l_wr_fire && l_rgn == RGN_RBOX) || (r_wr_fire && r_rgn == RGN_RBOX))
      |=> $stable(rbox));

  // R7: a left mailbox write lands its low byte
  a_r7_lbox_write: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_fire && l_rgn == RGN_LBOX) |=> (lbox == $past(l_wdata[BOX_W-1:0])));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 16,
  parameter int          BOX_W     = 8,
  parameter logic [15:0] LBOX_ADDR = 16'h0000,
  parameter logic [15:0] RBOX_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_rd_n,
  input  logic              l_wr_n,
  output logic [DATA_W-1:0] l_rdata,
  input  logic [15:0]       r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_rd_n,
  input  logic              r_wr_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              irq_to_right_n,
  output logic              irq_to_left_n
);
  import mbx_pkg::*;

  localparam int NSTROBE = 4;

  // Strobe order: left read, left write, right read, right write.
  logic [NSTROBE-1:0] strobe_n;
  logic [NSTROBE-1:0] fire;

  assign strobe_n = {r_wr_n, r_rd_n, l_wr_n, l_rd_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_edge
    mbx_strobe_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobe_n[g]),
      .fire     (fire[g])
    );
  end

  logic l_rd_fire, l_wr_fire, r_rd_fire, r_wr_fire;
  assign l_rd_fire = fire[0];
  assign l_wr_fire = fire[1];
  assign r_rd_fire = fire[2];
  assign r_wr_fire = fire[3];

  region_e l_rgn, r_rgn;
  assign l_rgn = decode_region(l_addr, LBOX_ADDR, RBOX_ADDR);
  assign r_rgn = decode_region(r_addr, LBOX_ADDR, RBOX_ADDR);

  // Named interrupt events
  logic ev_set_right, ev_clr_right, ev_set_left, ev_clr_left;
  assign ev_set_right = l_wr_fire && (l_rgn == RGN_LBOX);
  assign ev_clr_right = r_rd_fire && (r_rgn == RGN_LBOX);
  assign ev_set_left  = r_wr_fire && (r_rgn == RGN_RBOX);
  assign ev_clr_left  = l_rd_fire && (l_rgn == RGN_RBOX);

  mbx_irq_flag u_irq_right (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (ev_set_right),
    .clr_ev (ev_clr_right),
    .irq_n  (irq_to_right_n)
  );

  mbx_irq_flag u_irq_left (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (ev_set_left),
    .clr_ev (ev_clr_left),
    .irq_n  (irq_to_left_n)
  );

  logic [BOX_W-1:0] lbox, rbox;

  mbx_store #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BOX_W     (BOX_W),
    .LBOX_ADDR (LBOX_ADDR),
    .RBOX_ADDR (RBOX_ADDR)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_rd_fire (l_rd_fire),
    .l_wr_fire (l_wr_fire),
    .l_addr    (l_addr),
    .l_wdata   (l_wdata),
    .l_rdata   (l_rdata),
    .r_rd_fire (r_rd_fire),
    .r_wr_fire (r_wr_fire),
    .r_addr    (r_addr),
    .r_wdata   (r_wdata),
    .r_rdata   (r_rdata),
    .lbox      (lbox),
    .rbox      (rbox)
  );

  // R3: left mailbox write raises the right interrupt
  a_r3_right_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_n == 1'b0 && $past(l_wr_n) == 1'b1 && l_addr == LBOX_ADDR)
      |=> !irq_to_right_n);

  // R5: right mailbox write raises the left interrupt
  a_r5_left_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_left |=> !irq_to_left_n);

  // R6: lone left read of the right mailbox releases the left interrupt
  a_r6_left_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr_left && !ev_set_left) |=> irq_to_left_n);

  // R12: an interrupt falls only after its set event
  a_r12_right_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_to_right_n) |-> $past(ev_set_right));
  a_r12_left_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_to_left_n) |-> $past(ev_set_left));

  // R7: a mailbox read returns the byte zero-extended
  a_r7_box_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd_fire && l_rgn != RGN_STORE) |=> (l_rdata[DATA_W-1:BOX_W] == '0));

endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] LBOX = 16'h0000;
  localparam logic [15:0] RBOX = 16'h8000;
  localparam int OP_NONE = 0, OP_RD = 1, OP_WR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] l_addr = '0, l_wdata = '0, r_addr = '0, r_wdata = '0;
  logic        l_rd_n = 1'b1, l_wr_n = 1'b1, r_rd_n = 1'b1, r_wr_n = 1'b1;
  logic [15:0] l_rdata, r_rdata;
  logic        irq_to_right_n, irq_to_left_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_ctrl i_mbx_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rd_n(l_rd_n), .l_wr_n(l_wr_n), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rd_n(r_rd_n), .r_wr_n(r_wr_n), .r_rdata(r_rdata),
    .irq_to_right_n(irq_to_right_n), .irq_to_left_n(irq_to_left_n)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // Independent reference model
  logic [15:0] m_store [2048];
  logic [7:0]  m_lbox = 8'hFF, m_rbox = 8'hFF;
  logic        m_req_right = 1'b0, m_req_left = 1'b0;

  typedef struct {
    bit          right_port;
    logic [15:0] value;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [15:0] a);
    if (a == LBOX)      return {8'h00, m_lbox};
    else if (a == RBOX) return {8'h00, m_rbox};
    else                return m_store[a[10:0]];
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, e.right_port ? r_rdata : l_rdata, e.value);
    end
  end

  // Driver: one access per port, then one idle clock. Entered at a negedge.
  task automatic access(input int lop, input logic [15:0] la, input logic [15:0] ld,
                        input int rop, input logic [15:0] ra, input logic [15:0] rd,
                        input string tag);
    logic set_r, clr_r, set_l, clr_l;
    l_addr = la; l_wdata = ld; r_addr = ra; r_wdata = rd;
    l_rd_n = (lop != OP_RD); l_wr_n = (lop != OP_WR);
    r_rd_n = (rop != OP_RD); r_wr_n = (rop != OP_WR);
    @(negedge clk);
    l_rd_n = 1'b1; l_wr_n = 1'b1; r_rd_n = 1'b1; r_wr_n = 1'b1;
    if (lop == OP_RD) exp_q.push_back('{1'b0, m_read(la), {tag, " left read"}});
    if (rop == OP_RD) exp_q.push_back('{1'b1, m_read(ra), {tag, " right read"}});
    if (rop == OP_WR) begin
      if (ra == LBOX) m_lbox = rd[7:0];
      else if (ra == RBOX) m_rbox = rd[7:0];
      else m_store[ra[10:0]] = rd;
    end
    if (lop == OP_WR) begin
      if (la == LBOX) m_lbox = ld[7:0];
      else if (la == RBOX) m_rbox = ld[7:0];
      else m_store[la[10:0]] = ld;
    end
    set_r = (lop == OP_WR) && (la == LBOX);
    clr_r = (rop == OP_RD) && (ra == LBOX);
    set_l = (rop == OP_WR) && (ra == RBOX);
    clr_l = (lop == OP_RD) && (la == RBOX);
    m_req_right = set_r ? 1'b1 : (clr_r ? 1'b0 : m_req_right);
    m_req_left  = set_l ? 1'b1 : (clr_l ? 1'b0 : m_req_left);
    check({tag, " irq_to_right_n"}, {15'd0, irq_to_right_n}, {15'd0, ~m_req_right});
    check({tag, " irq_to_left_n"},  {15'd0, irq_to_left_n},  {15'd0, ~m_req_left});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq_to_right_n", {15'd0, irq_to_right_n}, 16'd1);
    check("R1 irq_to_left_n",  {15'd0, irq_to_left_n},  16'd1);
    check("R1 l_rdata", l_rdata, 16'h0000);
    check("R1 r_rdata", r_rdata, 16'h0000);
    access(OP_RD, LBOX, 0, OP_RD, RBOX, 0, "R1 mailbox reset");
    access(OP_RD, RBOX, 0, OP_RD, LBOX, 0, "R1 mailbox reset swap");

    // R3, R4, R7: left claims, right is told and reads
    access(OP_WR, LBOX, 16'h1200, OP_NONE, 0, 0, "R3 left box write");
    access(OP_NONE, 0, 0, OP_RD, LBOX, 0, "R4 R7 right reads left box");
    // R5, R6, R7: right releases, left is told and reads
    access(OP_NONE, 0, 0, OP_WR, RBOX, 16'hABFF, "R5 right box write");
    access(OP_RD, RBOX, 0, OP_NONE, 0, 0, "R6 R7 left reads right box");

    // R12: accesses that must not touch interrupts
    access(OP_WR, RBOX, 16'h0077, OP_NONE, 0, 0, "R12 left writes right box");
    access(OP_NONE, 0, 0, OP_WR, LBOX, 16'h0033, "R12 right writes left box");
    access(OP_WR, LBOX, 16'h0000, OP_NONE, 0, 0, "R3 raise again");
    access(OP_RD, LBOX, 0, OP_RD, RBOX, 0, "R12 reads of own boxes");
    access(OP_WR, 16'h0123, 16'hCAFE, OP_RD, 16'h0123, 0, "R12 R11 store traffic");
    access(OP_NONE, 0, 0, OP_RD, LBOX, 0, "R4 release");

    // R8: set and clear collide
    access(OP_WR, LBOX, 16'h0000, OP_RD, LBOX, 0, "R8 right collide");
    access(OP_NONE, 0, 0, OP_WR, RBOX, 16'h0000, "R5 raise left");
    access(OP_RD, RBOX, 0, OP_WR, RBOX, 16'h00FF, "R8 left collide");
    access(OP_NONE, 0, 0, OP_RD, LBOX, 0, "R4 after collide");
    access(OP_RD, RBOX, 0, OP_NONE, 0, 0, "R6 after collide");

    // R9: cross-port store traffic
    for (int i = 1; i <= 16; i++) begin
      logic [15:0] la, ra;
      la = 16'((i * 97 + 1) % 2048);
      ra = 16'(2047 - i * 53);
      access(OP_WR, la, 16'(i * 16'h1111 + 3), OP_WR, ra, 16'(16'h8000 ^ (i * 7)), "R9 write");
      access(OP_RD, ra, 0, OP_RD, la, 0, "R9 cross read");
    end
    access(OP_WR, 16'h07FF, 16'h5A5A, OP_NONE, 0, 0, "R9 top word");
    access(OP_RD, 16'h07FF, 0, OP_RD, 16'h07FF, 0, "R9 same word both ports");

    // R11: write collisions
    access(OP_WR, 16'h0200, 16'h1111, OP_WR, 16'h0200, 16'h2222, "R11 both write");
    access(OP_RD, 16'h0200, 0, OP_RD, 16'h0200, 0, "R11 left kept");
    access(OP_RD, 16'h0200, 0, OP_WR, 16'h0200, 16'h3333, "R11 read old");
    access(OP_NONE, 0, 0, OP_RD, 16'h0200, 0, "R11 new value");

    // R2: held strobe writes only the first data
    l_addr = 16'h0300; l_wdata = 16'hAAAA; l_wr_n = 1'b0;
    @(negedge clk); l_wdata = 16'hBBBB;
    @(negedge clk); l_wdata = 16'hCCCC;
    @(negedge clk); l_wr_n = 1'b1;
    m_store[11'h300] = 16'hAAAA;
    @(negedge clk);
    access(OP_NONE, 0, 0, OP_RD, 16'h0300, 0, "R2 held strobe");

    // R10: read data held over idle clocks
    access(OP_RD, 16'h0300, 0, OP_NONE, 0, 0, "R10 read");
    repeat (4) @(negedge clk);
    check("R10 l_rdata hold", l_rdata, 16'hAAAA);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 16'(exp_q.size()), 16'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule